// File: doc/BRIEF.md
# Dual-Channel Serial Interrupt Prioritizer

This block collects the interrupt sources of a two-channel serial controller and turns them into one interrupt request and an acknowledge vector. Each channel has three sources: receive, transmit and external/status. The receive source is shaped by a two-bit mode that either disables it, fires only on the first character after arming, fires on every character, or fires on special conditions only. The transmit source fires when the transmit buffer empties. The external/status source watches six level inputs and freezes a snapshot of them on the first enabled change.

The six sources have a fixed priority. An acknowledge strobe marks the highest requesting source as in service and returns a vector. The vector can carry a three-bit source code at one of two positions. Sources at or below the highest in-service level stay blocked until the host issues a reset-highest command. Host commands arrive as an eight-bit code with a channel select. They release the frozen snapshot, clear the transmit pending bit, clear special conditions and re-arm first-character mode. A daisy-chain enable input and output let several such blocks share one request line.

Top module: `sio_irq_prio`

## Requirements
- R1: `pending` bit 1 (B) or bit 4 (A) is set one cycle after a `tx_empty` strobe while that channel's `tx_ie` is 1. It stays 0 while `tx_ie` is 0. Command 0x28 to that channel clears it.
- R2: For each channel's `rx_mode`, 0 means a received character never sets the receive pending bit (bit 2 for B, bit 5 for A), 2 sets it on every character, and 3 ignores characters. With mode 1, only the first character after reset or after command 0x20 sets the bit. `rx_take` clears a character-caused pending bit.
- R3: In any nonzero `rx_mode`, an `rx_spec` strobe sets the receive pending bit. An `rx_par` strobe does the same only when `par_spec` is 1. Command 0x30 clears such a special condition.
- R4: While the snapshot is not frozen, `ext_latch` follows `ext_in`. A change on a bit whose `ext_mask` bit is 1 freezes the snapshot with the new value. While frozen, the external pending bit (bit 0 for B, bit 3 for A) equals `ext_ie`. Further changes leave `ext_latch` unchanged until command 0x10 releases the snapshot, after which it takes the current `ext_in`.
- R5: Priority from highest to lowest is A receive, A transmit, A external, B receive, B transmit, B external. An `ack` while `irq` is 1 sets the `in_service` bit of the highest unblocked pending source.
- R6: A pending source whose priority is at or below the highest set `in_service` bit does not raise `irq`. Command 0x38 on either channel clears only the highest set `in_service` bit.
- R7: `irq` is 1 only when `mie` and `iei` are both 1 and an unblocked source is pending.
- R8: One cycle after a granted `ack`, `vec_valid` pulses unless `no_vec` is 1. `vec` then equals `base_vec`, or, when `vis` is 1, `base_vec` with bits 3:1 (`stat_hi`=0) or bits 6:4 (`stat_hi`=1) replaced by the source code. The codes are: B transmit 0, B external 1, B receive 2, B special 3, A transmit 4, A external 5, A receive 6, A special 7.
- R9: `ieo` is 1 only when `iei` is 1, `dlc` is 0, no `in_service` bit is set and `irq` is 0.
- R10: After reset, `pending`, `in_service`, `irq` and `vec_valid` are 0, and first-character mode is armed on both channels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mie | input | 1 | Master interrupt enable |
| iei | input | 1 | Daisy-chain enable from higher-priority device |
| dlc | input | 1 | Block propagation to lower devices |
| no_vec | input | 1 | Suppress vector on acknowledge |
| vis | input | 1 | Vector carries source code |
| stat_hi | input | 1 | Code at bits 6:4 instead of 3:1 |
| base_vec | input | 8 | Base interrupt vector |
| ext_ie | input | 2 | External/status enable per channel ([0]=B, [1]=A) |
| tx_ie | input | 2 | Transmit interrupt enable per channel |
| par_spec | input | 2 | Parity error counts as special condition |
| rx_mode | input | 4 | Receive mode, [1:0]=B, [3:2]=A |
| ext_mask | input | 12 | Per-condition enables, [5:0]=B, [11:6]=A |
| rx_char | input | 2 | Character received strobe |
| rx_take | input | 2 | Host took the character |
| rx_spec | input | 2 | Special receive condition strobe |
| rx_par | input | 2 | Parity error strobe |
| tx_empty | input | 2 | Transmit buffer emptied strobe |
| ext_in | input | 12 | External/status condition levels |
| cmd_valid | input | 1 | Host command strobe |
| cmd_chan | input | 1 | Command target, 1=A, 0=B |
| cmd_code | input | 8 | Command code |
| ack | input | 1 | Interrupt acknowledge strobe |
| irq | output | 1 | Interrupt request |
| ieo | output | 1 | Daisy-chain enable to lower device |
| vec_valid | output | 1 | Vector valid pulse |
| vec | output | 8 | Interrupt vector |
| pending | output | 6 | Pending sources |
| in_service | output | 6 | In-service sources |
| ext_latch | output | 12 | External/status snapshot |

## Verification
A corrupted pending bit shows on `pending` one cycle after the stimulus edge, and on `irq` in the same cycle. A wrong in-service mask shows as `irq` staying low for a higher source, or rising early for a lower one. A wrong priority choice or code shows in the `vec` delivered one cycle after `ack`. A snapshot that is not held shows on `ext_latch` in the cycle after the ignored change.

// File: rtl/sio_irq_pkg.sv
package sio_irq_pkg;
    localparam int NUM_CH    = 2;
    localparam int SRC_PER_CH = 3;
    localparam int NUM_SRC   = NUM_CH * SRC_PER_CH;
    localparam int EXT_W     = 6;
    localparam int VEC_W     = 8;
    localparam int CODE_W    = 3;
    localparam int IDX_W     = $clog2(NUM_SRC);

    typedef enum logic [1:0] {
        RXM_OFF   = 2'd0,
        RXM_FIRST = 2'd1,
        RXM_ALL   = 2'd2,
        RXM_SPEC  = 2'd3
    } rx_mode_e;

    typedef enum logic [7:0] {
        CMD_EXT_RST = 8'h10,
        CMD_RX_ARM  = 8'h20,
        CMD_TX_RST  = 8'h28,
        CMD_ERR_RST = 8'h30,
        CMD_IUS_RST = 8'h38
    } cmd_e;

    typedef struct packed {
        logic             ext_ie;
        logic             tx_ie;
        logic             par_spec;
        rx_mode_e         rx_mode;
        logic [EXT_W-1:0] ext_mask;
    } chan_cfg_t;

    // source order inside a channel: 0 ext, 1 tx, 2 rx
    function automatic logic [CODE_W-1:0] src_code(input logic [IDX_W-1:0] idx,
                                                    input logic spec);
        logic               is_a;
        logic [IDX_W-1:0]   kind;
        is_a = (idx >= IDX_W'(SRC_PER_CH));
        kind = is_a ? idx - IDX_W'(SRC_PER_CH) : idx;
        case (kind)
            IDX_W'(0): src_code = {is_a, 2'b01};
            IDX_W'(1): src_code = {is_a, 2'b00};
            default:   src_code = {is_a, 1'b1, spec};
        endcase
    endfunction

    function automatic logic [VEC_W-1:0] place_code(input logic [VEC_W-1:0] base,
                                                     input logic [CODE_W-1:0] code,
                                                     input logic vis,
                                                     input logic hi);
        logic [VEC_W-1:0] v;
        v = base;
        if (vis) begin
            if (hi) v[6:4] = code;
            else    v[3:1] = code;
        end
        return v;
    endfunction
endpackage

// File: rtl/sio_irq_chan.sv
module sio_irq_chan
    import sio_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  chan_cfg_t        cfg,
    input  logic             ev_char,
    input  logic             ev_take,
    input  logic             ev_spec,
    input  logic             ev_par,
    input  logic             ev_txe,
    input  logic [EXT_W-1:0] ext_in,
    input  logic             cmd_hit,
    input  logic [7:0]       cmd_code,
    output logic [SRC_PER_CH-1:0] pend,
    output logic             rx_special,
    output logic [EXT_W-1:0] ext_snap
);
    logic             frozen, armed, chr_p, spc_p, tx_p;
    logic             do_ext_rst, do_arm, do_tx_rst, do_err_rst;
    logic             char_hits, spec_hits;

    always_comb begin
        do_ext_rst = cmd_hit && (cmd_code == CMD_EXT_RST);
        do_arm     = cmd_hit && (cmd_code == CMD_RX_ARM);
        do_tx_rst  = cmd_hit && (cmd_code == CMD_TX_RST);
        do_err_rst = cmd_hit && (cmd_code == CMD_ERR_RST);
        char_hits  = ev_char && ((cfg.rx_mode == RXM_ALL) ||
                                 ((cfg.rx_mode == RXM_FIRST) && armed));
        spec_hits  = (ev_spec || (ev_par && cfg.par_spec)) && (cfg.rx_mode != RXM_OFF);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            frozen   <= 1'b0;
            ext_snap <= '0;
            armed    <= 1'b1;
            chr_p    <= 1'b0;
            spc_p    <= 1'b0;
            tx_p     <= 1'b0;
        end else begin
            if (do_ext_rst) begin
                frozen   <= 1'b0;
                ext_snap <= ext_in;
            end else if (!frozen) begin
                ext_snap <= ext_in;
                if (|((ext_in ^ ext_snap) & cfg.ext_mask)) frozen <= 1'b1;
            end

            if (ev_txe && cfg.tx_ie) tx_p <= 1'b1;
            else if (do_tx_rst)      tx_p <= 1'b0;

            if (char_hits)    chr_p <= 1'b1;
            else if (ev_take) chr_p <= 1'b0;

            if (do_arm)                                        armed <= 1'b1;
            else if (ev_char && (cfg.rx_mode == RXM_FIRST))    armed <= 1'b0;

            if (spec_hits)       spc_p <= 1'b1;
            else if (do_err_rst) spc_p <= 1'b0;
        end
    end

    assign pend       = {chr_p | spc_p, tx_p, frozen & cfg.ext_ie};
    assign rx_special = spc_p;

    AST_SNAP_HELD: assert property (@(posedge clk) disable iff (rst)
        (frozen && !do_ext_rst) |=> $stable(ext_snap)); // R4
    AST_RX_OFF_QUIET: assert property (@(posedge clk) disable iff (rst)
        (cfg.rx_mode == RXM_OFF && !chr_p) |=> !chr_p); // R2
    AST_TX_GATED: assert property (@(posedge clk) disable iff (rst)
        (!cfg.tx_ie && !tx_p) |=> !tx_p); // R1
endmodule

// File: rtl/sio_irq_arb.sv
module sio_irq_arb
    import sio_irq_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] pend,
    input  logic [NUM_CH-1:0]  spec,
    input  logic               mie,
    input  logic               iei,
    input  logic               dlc,
    input  logic               no_vec,
    input  logic               vis,
    input  logic               stat_hi,
    input  logic [VEC_W-1:0]   base_vec,
    input  logic               ack,
    input  logic               ius_rst,
    output logic               irq,
    output logic               ieo,
    output logic [NUM_SRC-1:0] ius,
    output logic               vec_valid,
    output logic [VEC_W-1:0]   vec
);
    logic [NUM_SRC-1:0] blocked, req, ius_nxt;
    logic [IDX_W-1:0]   top, hi_ius;
    logic               acc, any_req, grant, top_spec;

    always_comb begin
        acc = 1'b0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            acc        = acc | ius[i];
            blocked[i] = acc;
        end
        req     = pend & ~blocked;
        any_req = |req;
        top     = '0;
        hi_ius  = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (req[i]) top    = IDX_W'(i);
            if (ius[i]) hi_ius = IDX_W'(i);
        end
        top_spec = (top >= IDX_W'(SRC_PER_CH)) ? spec[1] : spec[0];
        irq      = mie && iei && any_req;
        ieo      = iei && !dlc && !(|ius) && !irq;
        grant    = ack && irq;
        ius_nxt  = ius;
        if (grant)                 ius_nxt[top]    = 1'b1;
        else if (ius_rst && |ius)  ius_nxt[hi_ius] = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ius       <= '0;
            vec_valid <= 1'b0;
            vec       <= '0;
        end else begin
            ius       <= ius_nxt;
            vec_valid <= grant && !no_vec;
            if (grant) vec <= place_code(base_vec, src_code(top, top_spec), vis, stat_hi);
        end
    end

    AST_GRANT_ADDS_ONE: assert property (@(posedge clk) disable iff (rst)
        (ack && irq) |=> $countones(ius) == $countones($past(ius)) + 1); // R5
    AST_RESET_DROPS_ONE: assert property (@(posedge clk) disable iff (rst)
        (ius_rst && !(ack && irq) && |ius) |=> $countones(ius) + 1 == $countones($past(ius))); // R6
    AST_VEC_NEEDS_ACK: assert property (@(posedge clk) disable iff (rst)
        vec_valid |-> $past(ack && irq && !no_vec)); // R8
endmodule

// File: rtl/sio_irq_prio.sv
module sio_irq_prio
    import sio_irq_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    mie,
    input  logic                    iei,
    input  logic                    dlc,
    input  logic                    no_vec,
    input  logic                    vis,
    input  logic                    stat_hi,
    input  logic [VEC_W-1:0]        base_vec,
    input  logic [NUM_CH-1:0]       ext_ie,
    input  logic [NUM_CH-1:0]       tx_ie,
    input  logic [NUM_CH-1:0]       par_spec,
    input  logic [2*NUM_CH-1:0]     rx_mode,
    input  logic [NUM_CH*EXT_W-1:0] ext_mask,
    input  logic [NUM_CH-1:0]       rx_char,
    input  logic [NUM_CH-1:0]       rx_take,
    input  logic [NUM_CH-1:0]       rx_spec,
    input  logic [NUM_CH-1:0]       rx_par,
    input  logic [NUM_CH-1:0]       tx_empty,
    input  logic [NUM_CH*EXT_W-1:0] ext_in,
    input  logic                    cmd_valid,
    input  logic                    cmd_chan,
    input  logic [7:0]              cmd_code,
    input  logic                    ack,
    output logic                    irq,
    output logic                    ieo,
    output logic                    vec_valid,
    output logic [VEC_W-1:0]        vec,
    output logic [NUM_SRC-1:0]      pending,
    output logic [NUM_SRC-1:0]      in_service,
    output logic [NUM_CH*EXT_W-1:0] ext_latch
);
    logic [NUM_CH-1:0] spec_flag;
    logic              ius_rst;

    assign ius_rst = cmd_valid && (cmd_code == CMD_IUS_RST);

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        chan_cfg_t cfg;
        assign cfg = '{ext_ie:   ext_ie[g],
                       tx_ie:    tx_ie[g],
                       par_spec: par_spec[g],
                       rx_mode:  rx_mode_e'(rx_mode[2*g +: 2]),
                       ext_mask: ext_mask[g*EXT_W +: EXT_W]};

        sio_irq_chan u_chan (
            .clk        (clk),
            .rst        (rst),
            .cfg        (cfg),
            .ev_char    (rx_char[g]),
            .ev_take    (rx_take[g]),
            .ev_spec    (rx_spec[g]),
            .ev_par     (rx_par[g]),
            .ev_txe     (tx_empty[g]),
            .ext_in     (ext_in[g*EXT_W +: EXT_W]),
            .cmd_hit    (cmd_valid && (cmd_chan == 1'(g))),
            .cmd_code   (cmd_code),
            .pend       (pending[g*SRC_PER_CH +: SRC_PER_CH]),
            .rx_special (spec_flag[g]),
            .ext_snap   (ext_latch[g*EXT_W +: EXT_W])
        );
    end

    sio_irq_arb u_arb (
        .clk       (clk),
        .rst       (rst),
        .pend      (pending),
        .spec      (spec_flag),
        .mie       (mie),
        .iei       (iei),
        .dlc       (dlc),
        .no_vec    (no_vec),
        .vis       (vis),
        .stat_hi   (stat_hi),
        .base_vec  (base_vec),
        .ack       (ack),
        .ius_rst   (ius_rst),
        .irq       (irq),
        .ieo       (ieo),
        .ius       (in_service),
        .vec_valid (vec_valid),
        .vec       (vec)
    );
endmodule

// File: tb/sio_irq_prio_test.sv
module sio_irq_prio_test;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic mie = 1'b1, iei = 1'b1, dlc = 1'b0, no_vec = 1'b0, vis = 1'b0, stat_hi = 1'b0;
    logic [7:0]  base_vec = 8'h81;
    logic [1:0]  ext_ie = 2'b00, tx_ie = 2'b00, par_spec = 2'b00;
    logic [3:0]  rx_mode = 4'h0;
    logic [11:0] ext_mask = '0, ext_in = '0;
    logic [1:0]  rx_char = '0, rx_take = '0, rx_spec = '0, rx_par = '0, tx_empty = '0;
    logic        cmd_valid = 1'b0, cmd_chan = 1'b0;
    logic [7:0]  cmd_code = '0;
    logic        ack = 1'b0;
    logic        irq, ieo, vec_valid;
    logic [7:0]  vec;
    logic [5:0]  pending, in_service;
    logic [11:0] ext_latch;

    int total = 0, bad = 0;
    bit done = 0;
    logic [7:0] exp_q[$];

    always #4 clk = ~clk;

    sio_irq_prio uut (.*);

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic cmd(input logic ch, input logic [7:0] code);
        cmd_valid = 1'b1; cmd_chan = ch; cmd_code = code;
        tick();
        cmd_valid = 1'b0;
    endtask

    // expected vector from R8: code placed at bits 3:1 or 6:4
    function automatic logic [7:0] mkvec(input logic [2:0] code);
        logic [7:0] v;
        v = base_vec;
        if (vis) begin
            if (stat_hi) v[6:4] = code;
            else         v[3:1] = code;
        end
        return v;
    endfunction

    task automatic do_ack(input bit expect_vec, input logic [2:0] code);
        if (expect_vec) exp_q.push_back(mkvec(code));
        ack = 1'b1;
        tick();
        ack = 1'b0;
    endtask

    // monitor: pops expected vector on each vec_valid
    always @(negedge clk) begin
        if (!rst && vec_valid) begin
            if (exp_q.size() == 0) chk("R8 unexpected vector", {8'h0, vec}, 16'hFFFF);
            else chk("R8 vector", {8'h0, vec}, {8'h0, exp_q.pop_front()});
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        rst = 1'b0;
        tick();
        // R10 reset state
        chk("R10 pending", {10'h0, pending}, 16'h0);
        chk("R10 in_service", {10'h0, in_service}, 16'h0);
        chk("R10 irq", {15'h0, irq}, 16'h0);
        chk("R9 ieo idle", {15'h0, ieo}, 16'h1);

        // R1 transmit pending
        tx_empty[0] = 1'b1; tick(); tx_empty[0] = 1'b0; tick();
        chk("R1 tx gated off", {10'h0, pending}, 16'h0);
        tx_ie = 2'b11;
        tx_empty[0] = 1'b1; tick(); tx_empty[0] = 1'b0;
        chk("R1 B tx bit1", {10'h0, pending}, 16'h0002);
        chk("R7 irq up", {15'h0, irq}, 16'h1);
        chk("R9 ieo low on request", {15'h0, ieo}, 16'h0);
        mie = 1'b0; tick();
        chk("R7 mie gates", {15'h0, irq}, 16'h0);
        mie = 1'b1; iei = 1'b0; tick();
        chk("R7 iei gates", {15'h0, irq}, 16'h0);
        iei = 1'b1;
        cmd(1'b0, 8'h28);
        chk("R1 tx reset", {10'h0, pending}, 16'h0);

        // R2 receive modes, channel A
        rx_char[1] = 1'b1; tick(); rx_char[1] = 1'b0;
        chk("R2 mode off", {10'h0, pending}, 16'h0);
        rx_mode = 4'b1000;
        rx_char[1] = 1'b1; tick(); rx_char[1] = 1'b0;
        chk("R2 mode all", {10'h0, pending}, 16'h0020);
        rx_take[1] = 1'b1; tick(); rx_take[1] = 1'b0;
        chk("R2 take clears", {10'h0, pending}, 16'h0);
        rx_mode = 4'b0100;
        rx_char[1] = 1'b1; tick(); rx_char[1] = 1'b0;
        chk("R2 first char", {10'h0, pending}, 16'h0020);
        rx_take[1] = 1'b1; tick(); rx_take[1] = 1'b0;
        rx_char[1] = 1'b1; tick(); rx_char[1] = 1'b0;
        chk("R2 second char ignored", {10'h0, pending}, 16'h0);
        cmd(1'b1, 8'h20);
        rx_char[1] = 1'b1; tick(); rx_char[1] = 1'b0;
        chk("R2 rearmed", {10'h0, pending}, 16'h0020);
        rx_take[1] = 1'b1; tick(); rx_take[1] = 1'b0;
        rx_mode = 4'b1100;
        rx_char[1] = 1'b1; tick(); rx_char[1] = 1'b0;
        chk("R2 spec-only ignores char", {10'h0, pending}, 16'h0);

        // R3 special conditions
        rx_spec[1] = 1'b1; tick(); rx_spec[1] = 1'b0;
        chk("R3 special sets", {10'h0, pending}, 16'h0020);
        cmd(1'b1, 8'h30);
        chk("R3 error reset", {10'h0, pending}, 16'h0);
        rx_par[1] = 1'b1; tick(); rx_par[1] = 1'b0;
        chk("R3 parity not special", {10'h0, pending}, 16'h0);
        par_spec[1] = 1'b1;
        rx_par[1] = 1'b1; tick(); rx_par[1] = 1'b0;
        chk("R3 parity special", {10'h0, pending}, 16'h0020);
        cmd(1'b1, 8'h30);
        rx_mode = 4'b0000;

        // R4 external/status snapshot, channel B
        ext_ie[0] = 1'b1; ext_mask[5:0] = 6'b000010;
        ext_in[5:0] = 6'b000001; tick(); tick();
        chk("R4 masked change follows", {4'h0, ext_latch}, 16'h0001);
        chk("R4 masked no pend", {10'h0, pending}, 16'h0);
        ext_in[5:0] = 6'b000011; tick();
        chk("R4 freeze pend", {10'h0, pending}, 16'h0001);
        ext_in[5:0] = 6'b001001; tick(); tick();
        chk("R4 held latch", {4'h0, ext_latch}, 16'h0003);
        cmd(1'b0, 8'h10); tick();
        chk("R4 released pend", {10'h0, pending}, 16'h0);
        chk("R4 released latch", {4'h0, ext_latch}, 16'h0009);
        ext_ie[0] = 1'b0; ext_mask = '0;

        // R5/R6/R8 priority and vectors
        rx_mode = 4'b1010;
        tx_empty[1] = 1'b1; rx_char[0] = 1'b1; tick();
        tx_empty[1] = 1'b0; rx_char[0] = 1'b0;
        chk("R5 two pending", {10'h0, pending}, 16'h0014);
        do_ack(1, 3'd4);
        chk("R5 A tx in service", {10'h0, in_service}, 16'h0010);
        chk("R6 lower blocked", {15'h0, irq}, 16'h0);
        chk("R9 ieo low in service", {15'h0, ieo}, 16'h0);
        rx_char[1] = 1'b1; tick(); rx_char[1] = 1'b0;
        chk("R5 higher nests", {15'h0, irq}, 16'h1);
        vis = 1'b1;
        do_ack(1, 3'd6);
        chk("R5 nested service", {10'h0, in_service}, 16'h0030);
        cmd(1'b0, 8'h38);
        chk("R6 clears highest only", {10'h0, in_service}, 16'h0010);
        rx_take[1] = 1'b1; tick(); rx_take[1] = 1'b0;
        cmd(1'b1, 8'h28);
        chk("R6 still blocked", {15'h0, irq}, 16'h0);
        cmd(1'b1, 8'h38);
        chk("R6 unblocked", {15'h0, irq}, 16'h1);
        stat_hi = 1'b1;
        do_ack(1, 3'd2);
        cmd(1'b0, 8'h38);
        rx_spec[0] = 1'b1; tick(); rx_spec[0] = 1'b0;
        no_vec = 1'b1;
        do_ack(0, 3'd0);
        chk("R8 no_vec suppresses", {15'h0, vec_valid}, 16'h0);
        chk("R5 B rx in service", {10'h0, in_service}, 16'h0004);
        cmd(1'b0, 8'h38);
        no_vec = 1'b0;
        do_ack(1, 3'd3);
        cmd(1'b0, 8'h38);
        rx_take[0] = 1'b1; tick(); rx_take[0] = 1'b0;
        cmd(1'b0, 8'h30);
        tick();
        chk("R8 all vectors seen", 16'(exp_q.size()), 16'h0);
        chk("R9 ieo idle again", {15'h0, ieo}, 16'h1);
        dlc = 1'b1; tick();
        chk("R9 dlc blocks", {15'h0, ieo}, 16'h0);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule